// File: doc/BRIEF.md
# ALU Condition Flag Generator

This block sits beside an 8-bit arithmetic and logic datapath. It forms the operation result from two operands, an operation code and a carry input. It also keeps the five condition bits that later branch and arithmetic instructions read. These are zero, sign, parity, carry and the nibble carry (auxiliary carry). Each is held in its own flip-flop. Each one changes only on a clock edge where the update enable is high and the operation code is a known one.

The result is combinational from the inputs. The flags are registered one clock after the operation is presented. A write-back qualifier tells the surrounding datapath whether the result should be stored. It is low for compare, which exists only to set flags. The flags are also offered as one packed byte with fixed filler bits, ready to be pushed as a status word.

Top module: `cond_flag_unit`

## Requirements
- R1: `op_sel` codes: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 increment A, 6 decrement A, 7 AND, 8 OR, 9 XOR. `result` gives the 8-bit outcome combinationally (for compare, A minus B). `wr_ok` is high for every known code except compare.
- R2: After an update, `flag_z` is 1 exactly when the result was all zeros.
- R3: After an update, `flag_s` equals bit 7 of the result.
- R4: After an update, `flag_p` is 1 when the result holds an even number of 1 bits, and 0 when the count is odd.
- R5: `flag_cy` is set by a carry out of bit 7 on add and add with carry. It is set by a borrow on subtract, subtract with borrow and compare, where subtract with borrow computes A-B-carry_in. It is cleared by AND, OR and XOR.
- R6: `flag_ac` is the carry out of bit 3 of the internal sum, which is formed as follows. Add uses A+B. Add with carry uses A+B+cin. Subtract and compare use A+~B+1. Subtract with borrow uses A+~B+!cin. Increment uses A+1 and decrement uses A+0xFF. AND sets `flag_ac`; OR and XOR clear it.
- R7: Increment and decrement leave `flag_cy` at its previous value.
- R8: Compare sets all flags exactly as subtract does, with `wr_ok` low.
- R9: `flag_byte` = {S, Z, 0, AC, 0, P, 1, CY}, from bit 7 down to bit 0.
- R10: With `upd_en` low, all flags keep their values whatever the other inputs do.
- R11: Codes 10 to 15 leave all flags unchanged even with `upd_en` high. For these codes `result` equals A and `wr_ok` is 0.
- R12: An active-low reset clears all five flags, so `flag_byte` reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Flag update enable |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 8 | First operand (A) |
| opnd_b | input | 8 | Second operand (B) |
| carry_in | input | 1 | Carry/borrow input for add with carry and subtract with borrow |
| result | output | 8 | Operation result |
| wr_ok | output | 1 | Result is to be written back |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Even parity flag |
| flag_cy | output | 1 | Carry/borrow flag |
| flag_ac | output | 1 | Nibble carry flag |
| flag_byte | output | 8 | Packed flags |

## Verification
The bench builds the block with its defaults: an 8-bit data width, the nibble boundary at bit 4, and the logic-carry variant in which AND sets the nibble carry. With these values, hand-computed vectors reach every boundary case: wrap to zero on add and increment, borrows in both subtract forms, and carry preserved across increment and decrement. They also show the contrast between AND setting the nibble carry and OR/XOR clearing it. Directed steps then cover the enable hold, the unknown codes, and reset both at start and in mid-run.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_CMP = 4'd4,
      OP_INC = 4'd5,
      OP_DEC = 4'd6,
      OP_AND = 4'd7,
      OP_OR  = 4'd8,
      OP_XOR = 4'd9
   } op_e;

   typedef struct packed {
      logic s;
      logic z;
      logic ac;
      logic p;
      logic cy;
   } flags_t;
endpackage

// File: rtl/cfu_arith.sv
module cfu_arith
   import cfu_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int HALF_POS      = 4,
   parameter int LOGIC_AC_MODE = 1
) (
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output logic              cy_out,
   output logic              ac_out,
   output logic              cy_we,
   output logic              known,
   output logic              wr_ok
);
   localparam int SUM_W = DATA_W + 1;
   localparam int LOW_W = HALF_POS + 1;

   if (HALF_POS < 1 || HALF_POS >= DATA_W) begin : g_bad_half
      $error("HALF_POS must lie inside the data word");
   end
   if (LOGIC_AC_MODE < 0 || LOGIC_AC_MODE > 2) begin : g_bad_mode
      $error("LOGIC_AC_MODE must be 0, 1 or 2");
   end

   logic [DATA_W-1:0] bx;
   logic              cx;
   logic              is_sub;
   logic [SUM_W-1:0]  sum;
   logic [LOW_W-1:0]  low;
   logic              and_ac;

   // nibble carry produced by AND, chosen by variant
   if (LOGIC_AC_MODE == 0) begin : g_and_ac_clr
      assign and_ac = 1'b0;
   end else if (LOGIC_AC_MODE == 1) begin : g_and_ac_set
      assign and_ac = 1'b1;
   end else begin : g_and_ac_bits
      assign and_ac = a[HALF_POS-1] | b[HALF_POS-1];
   end

   always_comb begin
      bx     = b;
      cx     = 1'b0;
      is_sub = 1'b0;
      unique case (op_sel)
         OP_ADC:         cx = cin;
         OP_SUB, OP_CMP: begin bx = ~b; cx = 1'b1; is_sub = 1'b1; end
         OP_SBB:         begin bx = ~b; cx = ~cin; is_sub = 1'b1; end
         OP_INC:         begin bx = '0; cx = 1'b1; end
         OP_DEC:         bx = '1;
         default:        ;
      endcase
   end

   assign sum = {1'b0, a} + {1'b0, bx} + {{DATA_W{1'b0}}, cx};
   assign low = {1'b0, a[HALF_POS-1:0]} + {1'b0, bx[HALF_POS-1:0]}
              + {{HALF_POS{1'b0}}, cx};

   always_comb begin
      res    = sum[DATA_W-1:0];
      cy_out = sum[DATA_W] ^ is_sub;
      ac_out = low[HALF_POS];
      cy_we  = 1'b1;
      known  = 1'b1;
      wr_ok  = 1'b1;
      unique case (op_sel)
         OP_ADD, OP_ADC, OP_SUB, OP_SBB: ;
         OP_CMP:         wr_ok = 1'b0;
         OP_INC, OP_DEC: cy_we = 1'b0;
         OP_AND: begin res = a & b; cy_out = 1'b0; ac_out = and_ac; end
         OP_OR:  begin res = a | b; cy_out = 1'b0; ac_out = 1'b0; end
         OP_XOR: begin res = a ^ b; cy_out = 1'b0; ac_out = 1'b0; end
         default: begin
            res   = a;
            known = 1'b0;
            wr_ok = 1'b0;
            cy_we = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/cfu_status.sv
module cfu_status #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   output logic              zero,
   output logic              sign,
   output logic              even
);
   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end

   assign zero = (res == '0);
   assign sign = res[DATA_W-1];
   assign even = ~^res;
endmodule

// File: rtl/cfu_flag_regs.sv
module cfu_flag_regs
   import cfu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en,
   input  logic   cy_we,
   input  flags_t nxt,
   output flags_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (en) begin
         q.s  <= nxt.s;
         q.z  <= nxt.z;
         q.ac <= nxt.ac;
         q.p  <= nxt.p;
         if (cy_we) q.cy <= nxt.cy;
      end
   end

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q))
      else $error("flags changed while update disabled");
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
   import cfu_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int HALF_POS      = 4,
   parameter int LOGIC_AC_MODE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              wr_ok,
   output logic              flag_z,
   output logic              flag_s,
   output logic              flag_p,
   output logic              flag_cy,
   output logic              flag_ac,
   output logic [7:0]        flag_byte
);
   logic   cy_n, ac_n, cy_we, known;
   logic   z_n, s_n, p_n;
   flags_t nxt, cur;

   cfu_arith #(
      .DATA_W(DATA_W), .HALF_POS(HALF_POS), .LOGIC_AC_MODE(LOGIC_AC_MODE)
   ) u_arith (
      .op_sel(op_sel), .a(opnd_a), .b(opnd_b), .cin(carry_in),
      .res(result), .cy_out(cy_n), .ac_out(ac_n), .cy_we(cy_we),
      .known(known), .wr_ok(wr_ok)
   );

   cfu_status #(.DATA_W(DATA_W)) u_status (
      .res(result), .zero(z_n), .sign(s_n), .even(p_n)
   );

   assign nxt = '{s: s_n, z: z_n, ac: ac_n, p: p_n, cy: cy_n};

   cfu_flag_regs u_regs (
      .clk(clk), .rst_n(rst_n), .en(upd_en & known),
      .cy_we(cy_we), .nxt(nxt), .q(cur)
   );

   assign flag_z    = cur.z;
   assign flag_s    = cur.s;
   assign flag_p    = cur.p;
   assign flag_cy   = cur.cy;
   assign flag_ac   = cur.ac;
   assign flag_byte = {cur.s, cur.z, 1'b0, cur.ac, 1'b0, cur.p, 1'b1, cur.cy};

   // R2
   zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && known) |=> (flag_z == ($past(result) == '0)))
      else $error("zero flag mismatch");

   // R3
   sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && known) |=> (flag_s == $past(result[DATA_W-1])))
      else $error("sign flag mismatch");

   // R7
   cy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && (op_sel == OP_INC || op_sel == OP_DEC)) |=> $stable(flag_cy))
      else $error("carry changed on increment/decrement");

   // R11
   unknown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && op_sel > OP_XOR) |=> $stable(flag_byte))
      else $error("flags changed on unknown code");
endmodule

// File: tb/cond_flag_unit_bench.sv
module cond_flag_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 22;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_en = 1'b0;
   logic [3:0] op_sel = '0;
   logic [7:0] opnd_a = '0, opnd_b = '0;
   logic       carry_in = 1'b0;
   logic [7:0] result, flag_byte;
   logic       wr_ok, flag_z, flag_s, flag_p, flag_cy, flag_ac;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cond_flag_unit u_cond_flag_unit (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_sel(op_sel),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .carry_in(carry_in),
      .result(result), .wr_ok(wr_ok), .flag_z(flag_z), .flag_s(flag_s),
      .flag_p(flag_p), .flag_cy(flag_cy), .flag_ac(flag_ac),
      .flag_byte(flag_byte)
   );

   // {op, a, b, cin, result, flag_byte, wr_ok}
   localparam logic [37:0] VEC [NVEC] = '{
      {4'd0, 8'h3A, 8'hC6, 1'b0, 8'h00, 8'h57, 1'b1},
      {4'd0, 8'h12, 8'h34, 1'b0, 8'h46, 8'h02, 1'b1},
      {4'd1, 8'h0F, 8'h00, 1'b1, 8'h10, 8'h12, 1'b1},
      {4'd1, 8'hFF, 8'h00, 1'b1, 8'h00, 8'h57, 1'b1},
      {4'd2, 8'h10, 8'h01, 1'b0, 8'h0F, 8'h06, 1'b1},
      {4'd2, 8'h05, 8'h07, 1'b0, 8'hFE, 8'h83, 1'b1},
      {4'd2, 8'h44, 8'h44, 1'b0, 8'h00, 8'h56, 1'b1},
      {4'd3, 8'h10, 8'h0F, 1'b1, 8'h00, 8'h46, 1'b1},
      {4'd3, 8'h00, 8'h00, 1'b1, 8'hFF, 8'h87, 1'b1},
      {4'd4, 8'h20, 8'h30, 1'b0, 8'hF0, 8'h97, 1'b0},
      {4'd5, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h57, 1'b1},
      {4'd6, 8'h00, 8'h00, 1'b0, 8'hFF, 8'h87, 1'b1},
      {4'd0, 8'h01, 8'h01, 1'b0, 8'h02, 8'h02, 1'b1},
      {4'd5, 8'h7F, 8'h00, 1'b0, 8'h80, 8'h92, 1'b1},
      {4'd6, 8'h10, 8'h00, 1'b0, 8'h0F, 8'h06, 1'b1},
      {4'd7, 8'hF0, 8'h3C, 1'b0, 8'h30, 8'h16, 1'b1},
      {4'd7, 8'h0F, 8'hF0, 1'b0, 8'h00, 8'h56, 1'b1},
      {4'd2, 8'h00, 8'h01, 1'b0, 8'hFF, 8'h87, 1'b1},
      {4'd8, 8'h80, 8'h01, 1'b0, 8'h81, 8'h86, 1'b1},
      {4'd9, 8'h5A, 8'h5A, 1'b0, 8'h00, 8'h46, 1'b1},
      {4'd9, 8'h01, 8'h02, 1'b0, 8'h03, 8'h06, 1'b1},
      {4'd0, 8'h80, 8'h80, 1'b0, 8'h00, 8'h47, 1'b1}
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_flags(input string ctx, input logic [7:0] fb);
      check({ctx, " R9 flag_byte"}, flag_byte, fb);
      check({ctx, " R2 zero"}, {7'd0, flag_z}, {7'd0, fb[6]});
      check({ctx, " R3 sign"}, {7'd0, flag_s}, {7'd0, fb[7]});
      check({ctx, " R4 parity"}, {7'd0, flag_p}, {7'd0, fb[2]});
      check({ctx, " R5 carry"}, {7'd0, flag_cy}, {7'd0, fb[0]});
      check({ctx, " R6 nibble carry"}, {7'd0, flag_ac}, {7'd0, fb[4]});
   endtask

   task automatic apply(input logic en, input logic [3:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic ci);
      @(negedge clk);
      upd_en = en; op_sel = op; opnd_a = a; opnd_b = b; carry_in = ci;
      #1;
   endtask

   task automatic settle();
      @(posedge clk);
      #1;
      upd_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R12 reset state
      repeat (3) @(posedge clk);
      #1;
      check_flags("reset R12", 8'h02);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: R1 result/wr_ok, R2-R9 flags
      for (int i = 0; i < NVEC; i++) begin
         apply(1'b1, VEC[i][37:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17]);
         check($sformatf("vec%0d R1 result", i), result, VEC[i][16:9]);
         check($sformatf("vec%0d R1 wr_ok", i), {7'd0, wr_ok}, {7'd0, VEC[i][0]});
         settle();
         check_flags($sformatf("vec%0d", i), VEC[i][8:1]);
      end

      // R10: update disabled, flags stay 0x47 while result follows inputs
      apply(1'b0, 4'd0, 8'h01, 8'h01, 1'b0);
      check("R10 result live", result, 8'h02);
      settle();
      check_flags("R10 hold", 8'h47);

      // R11: unknown code holds flags, result = A, wr_ok low
      apply(1'b1, 4'd12, 8'h5C, 8'h33, 1'b1);
      check("R11 result", result, 8'h5C);
      check("R11 wr_ok", {7'd0, wr_ok}, 8'h00);
      settle();
      check_flags("R11 hold", 8'h47);

      // R7: carry stays set through increment
      apply(1'b1, 4'd5, 8'h00, 8'hFF, 1'b0);
      check("R7 inc result", result, 8'h01);
      settle();
      check("R7 carry kept", {7'd0, flag_cy}, 8'h01);
      check_flags("R7", 8'h03);

      // R8: compare equals subtract in flags, no write-back
      apply(1'b1, 4'd4, 8'h44, 8'h44, 1'b0);
      check("R8 wr_ok", {7'd0, wr_ok}, 8'h00);
      settle();
      check("R8 flags as subtract", flag_byte, 8'h56);

      // R12: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R12 async reset", flag_byte, 8'h02);
      @(negedge clk);
      rst_n = 1'b1;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule